// File: doc/BRIEF.md
# I2C master transfer engine

This block is a byte-level I2C master. One request to the block carries a 7-bit slave address, a direction bit and a 5-bit read length. From that request it generates the whole bus transaction. The transaction opens with a start condition and sends the address byte. In a write it then sends bytes taken from a transmit queue. In a read it clocks in the programmed number of bytes, places them in a receive queue and acknowledges them itself. It closes with a stop condition.

Both bus lines are open-drain. The block only drives an output-enable for each line, and the bus is pulled high when neither side pulls it low. A new request written while a transaction is running is held as pending. When the current transaction reaches its natural end, the block issues a repeated start instead of a stop and carries on with the new address and direction. The serial clock comes from the system clock through a fixed divider, with four phases per bit.

Top module: `i2cm_engine`

## Requirements
- R1: After reset both line enables are 0 (lines released), `busy_o` and `nack_o` are 0 and the receive queue is empty.
- R2: A request written while idle produces a start condition (SDA falls while SCL is high). The start is followed by an address frame holding `addr_i[7:1]` then `addr_i[0]`, where 1 means read and 0 means write. Every frame is 9 SCL pulses: 8 data bits, most significant first, then one acknowledge bit.
- R3: In a write, the bytes in the transmit queue are sent in push order after the address frame. The master releases SDA during each acknowledge bit.
- R4: A write ends with a stop condition (SDA rises while SCL is high) once the transmit queue is empty and no request is pending.
- R5: In a read, `count_i` bytes are received and pushed in order into the receive queue. The master releases SDA during data bits. It drives the acknowledge bit low for every byte except the last, which it answers with a release (NACK), and then it sends a stop. A count of 0 gives a stop right after the address frame.
- R6: A high acknowledge bit from the slave on any frame the master sends (address or data) sets `nack_o`. It also ends the transaction with a stop, empties the transmit queue and discards any pending request. The next request clears `nack_o`.
- R7: A request written while `busy_o` is 1 does not start a second transaction. At the natural end of the current one, the block sends a repeated start with no stop in between, followed by the new address frame and transfer.
- R8: `busy_o` is 1 from the clock after an idle request until the stop completes. It is 1 whenever the master pulls either line low.
- R9: SDA changes while SCL is high only for start and stop conditions.
- R10: The transmit queue holds `TX_DEPTH` (default 4) bytes. `tx_full_o` is 1 when it is full, and pushes into a full queue are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_we_i | input | 1 | Request strobe: latches address, direction and count |
| addr_i | input | 8 | [7:1] slave address, [0] direction (1 read) |
| count_i | input | 5 | Read length in bytes |
| tx_push_i | input | 1 | Push a byte into the transmit queue |
| tx_data_i | input | 8 | Byte to push |
| tx_full_o | output | 1 | Transmit queue full |
| rx_pop_i | input | 1 | Pop the head of the receive queue |
| rx_data_o | output | 8 | Head of the receive queue |
| rx_empty_o | output | 1 | Receive queue empty |
| sda_i | input | 1 | Sensed level of the data line |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Transaction active |
| nack_o | output | 1 | Slave did not acknowledge |

## Verification
The bench attacks the ends of frames and transactions. A read of length one or three shows whether the master NACKs the right byte: an off-by-one length either leaves the slave driving SDA into the stop or clocks one byte too many. A NACK on the address frame and another on a middle data byte check the abort path. A design that skipped the flush would send leftover bytes at the start of the next write, and one that missed the abort would keep clocking the bus. A request written during a write must produce a repeated start with no stop in between. Pushing six bytes into a four-deep queue shows whether extra bytes leak onto the bus.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BIT, ST_STOP} st_e;

  typedef struct packed {
    logic [6:0] dev;
    logic       rd;
    logic [4:0] cnt;
  } req_t;
endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign data_o  = mem_q[rd_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  // R10
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  // R10
  full_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o);
endmodule

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!run_i || tick_o)      cnt_q <= '0;
    else                            cnt_q <= cnt_q + CW'(1);
  end

  generate
    if (DIV > 1) begin : g_gap
      // R8
      tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       req_we_i,
  input  req_t       req_i,
  input  logic       sda_i,
  input  logic       tx_empty_i,
  input  logic [7:0] tx_data_i,
  output logic       tx_pop_o,
  output logic       tx_flush_o,
  output logic       rx_push_o,
  output logic [7:0] rx_data_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       busy_o,
  output logic       nack_o
);
  st_e        state_q;
  logic [1:0] ph_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q;
  req_t       cur_q, pend_req_q;
  logic       pend_q;
  logic       rx_frame_q, addr_frame_q;
  logic [4:0] left_q;
  logic       ack_q, nack_q;
  logic       scl_q, sda_q;

  logic frame_end, nack_abort, rd_begin, tx_next, rd_more;

  assign frame_end  = tick_i && (state_q == ST_BIT) && (ph_q == 2'd3) && (bit_q == 4'd8);
  assign nack_abort = !rx_frame_q && ack_q;
  assign rd_begin   = !rx_frame_q && !ack_q && addr_frame_q && cur_q.rd && (cur_q.cnt != '0);
  assign tx_next    = !rx_frame_q && !ack_q && !(addr_frame_q && cur_q.rd) && !tx_empty_i;
  assign rd_more    = rx_frame_q && (left_q != 5'd1);

  assign tx_pop_o   = frame_end && tx_next;
  assign tx_flush_o = frame_end && nack_abort;
  assign rx_push_o  = frame_end && rx_frame_q;
  assign rx_data_o  = sh_q;
  assign scl_oe_o   = scl_q;
  assign sda_oe_o   = sda_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign nack_o     = nack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      ph_q         <= '0;
      bit_q        <= '0;
      sh_q         <= '0;
      cur_q        <= '0;
      pend_req_q   <= '0;
      pend_q       <= 1'b0;
      rx_frame_q   <= 1'b0;
      addr_frame_q <= 1'b0;
      left_q       <= '0;
      ack_q        <= 1'b0;
      nack_q       <= 1'b0;
      scl_q        <= 1'b0;
      sda_q        <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_we_i) begin
            cur_q   <= req_i;
            nack_q  <= 1'b0;
            ph_q    <= '0;
            state_q <= ST_START;
          end
        end
        ST_START: begin
          if (tick_i) begin
            ph_q <= ph_q + 2'd1;
            unique case (ph_q)
              2'd0: sda_q <= 1'b0;
              2'd1: scl_q <= 1'b0;
              2'd2: sda_q <= 1'b1;            // start: SDA low under high SCL
              2'd3: begin
                scl_q        <= 1'b1;
                sh_q         <= {cur_q.dev, cur_q.rd};
                bit_q        <= '0;
                rx_frame_q   <= 1'b0;
                addr_frame_q <= 1'b1;
                state_q      <= ST_BIT;
              end
            endcase
          end
        end
        ST_BIT: begin
          if (tick_i) begin
            ph_q <= ph_q + 2'd1;
            unique case (ph_q)
              2'd0: begin
                if (bit_q == 4'd8) sda_q <= rx_frame_q && (left_q != 5'd1);
                else               sda_q <= !rx_frame_q && !sh_q[7];
              end
              2'd1: scl_q <= 1'b0;
              2'd2: begin
                if (bit_q == 4'd8)   ack_q <= sda_i;
                else if (rx_frame_q) sh_q  <= {sh_q[6:0], sda_i};
              end
              2'd3: begin
                scl_q <= 1'b1;
                if (bit_q != 4'd8) begin
                  bit_q <= bit_q + 4'd1;
                  if (!rx_frame_q) sh_q <= {sh_q[6:0], 1'b0};
                end else begin
                  bit_q <= '0;
                  if (nack_abort) begin
                    nack_q  <= 1'b1;
                    pend_q  <= 1'b0;
                    state_q <= ST_STOP;
                  end else if (rd_begin) begin
                    addr_frame_q <= 1'b0;
                    rx_frame_q   <= 1'b1;
                    left_q       <= cur_q.cnt;
                  end else if (tx_next) begin
                    addr_frame_q <= 1'b0;
                    sh_q         <= tx_data_i;
                  end else if (rd_more) begin
                    left_q <= left_q - 5'd1;
                  end else if (pend_q) begin
                    cur_q   <= pend_req_q;
                    pend_q  <= 1'b0;
                    state_q <= ST_START;      // repeated start
                  end else begin
                    state_q <= ST_STOP;
                  end
                end
              end
            endcase
          end
        end
        ST_STOP: begin
          if (tick_i) begin
            ph_q <= ph_q + 2'd1;
            unique case (ph_q)
              2'd0: sda_q <= 1'b1;
              2'd1: scl_q <= 1'b0;
              2'd2: sda_q <= 1'b0;            // stop: SDA rises under high SCL
              2'd3: begin
                if (pend_q) begin
                  cur_q   <= pend_req_q;
                  pend_q  <= 1'b0;
                  nack_q  <= 1'b0;
                  state_q <= ST_START;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (req_we_i && state_q != ST_IDLE) begin
        pend_q     <= 1'b1;
        pend_req_q <= req_i;
      end
    end
  end

  // R9
  sda_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BIT && $past(state_q) == ST_BIT && !scl_q && !$past(scl_q))
      |-> $stable(sda_q));

  // R5
  rd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BIT && rx_frame_q && bit_q != 4'd8 && ph_q != 2'd0) |-> !sda_q);

  // R6
  nack_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nack_q) |-> (state_q == ST_STOP));

  // R8
  busy_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_q || sda_q) |-> busy_o);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int CLK_DIV  = 8,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       addr_we_i,
  input  logic [7:0] addr_i,
  input  logic [4:0] count_i,
  input  logic       tx_push_i,
  input  logic [7:0] tx_data_i,
  output logic       tx_full_o,
  input  logic       rx_pop_i,
  output logic [7:0] rx_data_o,
  output logic       rx_empty_o,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       busy_o,
  output logic       nack_o
);
  logic       tick;
  logic       tx_empty, tx_pop, tx_flush;
  logic [7:0] tx_head;
  logic       rx_push, rx_full;
  logic [7:0] rx_byte;
  req_t       req;

  assign req = '{dev: addr_i[7:1], rd: addr_i[0], cnt: count_i};

  i2cm_tick #(.DIV(CLK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_o),
    .tick_o(tick)
  );

  i2cm_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(tx_flush),
    .push_i (tx_push_i),
    .data_i (tx_data_i),
    .pop_i  (tx_pop),
    .data_o (tx_head),
    .empty_o(tx_empty),
    .full_o (tx_full_o)
  );

  i2cm_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(1'b0),
    .push_i (rx_push),
    .data_i (rx_byte),
    .pop_i  (rx_pop_i),
    .data_o (rx_data_o),
    .empty_o(rx_empty_o),
    .full_o (rx_full)
  );

  i2cm_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .req_we_i  (addr_we_i),
    .req_i     (req),
    .sda_i     (sda_i),
    .tx_empty_i(tx_empty),
    .tx_data_i (tx_head),
    .tx_pop_o  (tx_pop),
    .tx_flush_o(tx_flush),
    .rx_push_o (rx_push),
    .rx_data_o (rx_byte),
    .scl_oe_o  (scl_oe_o),
    .sda_oe_o  (sda_oe_o),
    .busy_o    (busy_o),
    .nack_o    (nack_o)
  );

  // R5
  rx_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push |-> (!rx_full || rx_pop_i));
endmodule

// File: tb/tb_i2cm_engine.sv
module tb_i2cm_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] SLV = 7'h2C;
  localparam logic [6:0] BAD = 7'h13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_we = 1'b0;
  logic [7:0] addr = '0;
  logic [4:0] count = '0;
  logic       tx_push = 1'b0;
  logic [7:0] tx_data = '0;
  logic       rx_pop = 1'b0;
  logic       tx_full, rx_empty, scl_oe, sda_oe, busy, nack;
  logic [7:0] rx_data;
  logic       slv_oe = 1'b0;
  logic       scl_bus, sda_bus;

  assign scl_bus = !scl_oe;
  assign sda_bus = !(sda_oe || slv_oe);

  i2cm_engine #(.CLK_DIV(4), .TX_DEPTH(4), .RX_DEPTH(4)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .addr_we_i(addr_we), .addr_i(addr), .count_i(count),
    .tx_push_i(tx_push), .tx_data_i(tx_data), .tx_full_o(tx_full),
    .rx_pop_i(rx_pop), .rx_data_o(rx_data), .rx_empty_o(rx_empty),
    .sda_i(sda_bus), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .busy_o(busy), .nack_o(nack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int log_q[$];
  int exp_q[$];
  logic [7:0] rd_src[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // behavioural slave and bus monitor: events -1 start, -2 stop, else byte*2+ack
  logic       pscl = 1'b1, psda = 1'b1;
  logic [7:0] ssh = '0, cur_rd = '0;
  int         bitn = 0, wr_idx = 0, nack_at = -1;
  bit         is_addr = 0, rd_mode = 0, quiet = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_oe || sda_oe) chk(busy, "R8 busy while driving", busy, 1);
      if (scl_bus && pscl && psda && !sda_bus) begin
        log_q.push_back(-1);
        bitn = 0; wr_idx = 0; is_addr = 1; quiet = 0; slv_oe = 1'b0;
      end else if (scl_bus && pscl && !psda && sda_bus) begin
        log_q.push_back(-2);
        quiet = 1; slv_oe = 1'b0;
      end else if (scl_bus && !pscl) begin
        if (bitn < 8) begin
          ssh = {ssh[6:0], sda_bus};
          bitn++;
        end else begin
          log_q.push_back(int'(ssh) * 2 + int'(sda_bus));
          if (is_addr) begin
            rd_mode = ssh[0];
            if (ssh[7:1] != SLV) quiet = 1;
          end else if (rd_mode && sda_bus) begin
            quiet = 1;
          end else if (!rd_mode) begin
            wr_idx++;
          end
          is_addr = 0;
          bitn = 0;
        end
      end else if (!scl_bus && pscl) begin
        if (quiet) slv_oe = 1'b0;
        else if (bitn == 8) begin
          if (is_addr)      slv_oe = (ssh[7:1] == SLV);
          else if (!rd_mode) slv_oe = (wr_idx != nack_at);
          else              slv_oe = 1'b0;
        end else if (!is_addr && rd_mode) begin
          if (bitn == 0) cur_rd = (rd_src.size() > 0) ? rd_src.pop_front() : 8'hA5;
          slv_oe = !cur_rd[7 - bitn];
        end else slv_oe = 1'b0;
      end
      pscl = scl_bus;
      psda = sda_bus;
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      summary();
    end
  end

  task automatic request(input logic [6:0] a, input logic rd, input logic [4:0] c);
    @(negedge clk);
    addr_we = 1'b1; addr = {a, rd}; count = c;
    @(negedge clk);
    addr_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    tx_push = 1'b1; tx_data = b;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic compare_log(input string req);
    chk(log_q.size() == exp_q.size(), {req, " event count"}, log_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
      chk(log_q[i] == exp_q[i], {req, " bus event"}, log_q[i], exp_q[i]);
    log_q.delete();
    exp_q.delete();
  endtask

  function automatic int fr(input logic [7:0] b, input bit a);
    return int'(b) * 2 + int'(a);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(!busy, "R1 busy", busy, 0);
    chk(!nack, "R1 nack", nack, 0);
    chk(rx_empty, "R1 rx empty", rx_empty, 1);

    // R2 R3 R4 write of three bytes
    push(8'hA1); push(8'hB2); push(8'hC3);
    request(SLV, 1'b0, 5'd0);
    chk(busy, "R8 busy after request", busy, 1);
    wait_idle();
    exp_q = '{-1, fr({SLV,1'b0},0), fr(8'hA1,0), fr(8'hB2,0), fr(8'hC3,0), -2};
    compare_log("R3 write");
    chk(!nack, "R4 no nack", nack, 0);

    // R5 read of three bytes
    rd_src = '{8'h5A, 8'hC3, 8'h0F};
    request(SLV, 1'b1, 5'd3);
    wait_idle();
    exp_q = '{-1, fr({SLV,1'b1},0), fr(8'h5A,0), fr(8'hC3,0), fr(8'h0F,1), -2};
    compare_log("R5 read");
    foreach (exp_q[i]) ;
    begin
      logic [7:0] want [3] = '{8'h5A, 8'hC3, 8'h0F};
      for (int i = 0; i < 3; i++) begin
        chk(!rx_empty && rx_data == want[i], "R5 rx data", rx_data, want[i]);
        @(negedge clk); rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
      end
    end
    chk(rx_empty, "R5 rx drained", rx_empty, 1);

    // R5 read of length one and length zero
    rd_src = '{8'h3C};
    request(SLV, 1'b1, 5'd1);
    wait_idle();
    exp_q = '{-1, fr({SLV,1'b1},0), fr(8'h3C,1), -2};
    compare_log("R5 single read");
    chk(rx_data == 8'h3C, "R5 single rx", rx_data, 8'h3C);
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
    request(SLV, 1'b1, 5'd0);
    wait_idle();
    exp_q = '{-1, fr({SLV,1'b1},0), -2};
    compare_log("R5 zero read");

    // R6 address not acknowledged, queued data flushed
    push(8'h11); push(8'h22);
    request(BAD, 1'b0, 5'd0);
    wait_idle();
    exp_q = '{-1, fr({BAD,1'b0},1), -2};
    compare_log("R6 address nack");
    chk(nack, "R6 nack set", nack, 1);
    request(SLV, 1'b0, 5'd0);
    chk(!nack, "R6 nack cleared", nack, 0);
    wait_idle();
    exp_q = '{-1, fr({SLV,1'b0},0), -2};
    compare_log("R6 queue flushed");

    // R6 data byte not acknowledged
    nack_at = 1;
    push(8'h44); push(8'h55); push(8'h66);
    request(SLV, 1'b0, 5'd0);
    wait_idle();
    exp_q = '{-1, fr({SLV,1'b0},0), fr(8'h44,0), fr(8'h55,1), -2};
    compare_log("R6 data nack");
    chk(nack, "R6 nack after data", nack, 1);
    nack_at = -1;

    // R7 request while busy gives repeated start
    rd_src = '{8'h9C, 8'hE1};
    push(8'h77); push(8'h88);
    request(SLV, 1'b0, 5'd0);
    repeat (20) @(negedge clk);
    request(SLV, 1'b1, 5'd2);
    wait_idle();
    exp_q = '{-1, fr({SLV,1'b0},0), fr(8'h77,0), fr(8'h88,0),
              -1, fr({SLV,1'b1},0), fr(8'h9C,0), fr(8'hE1,1), -2};
    compare_log("R7 repeated start");
    chk(!nack, "R7 nack clear", nack, 0);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
    end

    // R10 overfilled transmit queue
    for (int i = 1; i <= 6; i++) begin
      push(8'(i));
      if (i == 4) chk(tx_full, "R10 full at depth", tx_full, 1);
    end
    request(SLV, 1'b0, 5'd0);
    wait_idle();
    exp_q = '{-1, fr({SLV,1'b0},0), fr(8'h01,0), fr(8'h02,0), fr(8'h03,0), fr(8'h04,0), -2};
    compare_log("R10 extra pushes ignored");
    chk(!tx_full, "R10 queue drained", tx_full, 0);
    chk(!busy && !scl_oe && !sda_oe, "R4 idle after stop", {busy, scl_oe, sda_oe}, 0);

    summary();
  end
endmodule